// File: doc/BRIEF.md
# Two-Wire Byte-Stepped Master Engine

This block is a master-only controller for a two-wire serial bus. It does not run whole transactions on its own. Software advances it one bus event at a time through a small register set. A control write can ask for a start condition, a stop condition, or the transfer of one byte. When that event is finished, the engine raises an interrupt flag and publishes an 8-bit status code that tells software what happened on the bus. Software reads the code, loads the next byte into the data register, and writes control again to clear the flag and start the next step.

The first byte after any start is the address byte. It holds the 7-bit target address in bits 7:1, and bit 0 is 1 for a read. Bit 0 sets whether the data bytes that follow are sent or received. When the master receives a byte, it returns ACK only if the acknowledge bit was set in the control write that launched that byte. Software clears that bit for the final byte so that the master returns NACK.

Both bus lines are open-drain. An output of 1 releases the line, and the line inputs show the wired state of the bus. Each bit is split into four quarter phases, and each phase lasts `QTR_CYCLES` clocks. A phase that follows a release of SCL waits while another device holds SCL low.

Top module: `twm_byte_engine`

## Requirements
- R1: After the asynchronous reset, or after a write to write-select 2 (soft reset), the status register (read-select 2) holds 0xF8, the interrupt flag is low and both line outputs are released. This applies at any time, including in the middle of a byte.
- R2: A control write (write-select 1) with bit 6 (enable) and bit 5 (start) set, sent while the bus is free, makes SDA fall while SCL is high and then pulls SCL low. The status becomes 0x08 and the flag is set.
- R3: The same start request sent while the bus is held by this master (after a start and before a stop) produces a repeated start, with status 0x10.
- R4: The address byte is shifted out MSB first from the data register (write-select 0). On a write address (bit 0 = 0) the status becomes 0x18 if ACKed and 0x20 if NACKed. On a read address (bit 0 = 1) it becomes 0x40 if ACKed and 0x48 if NACKed.
- R5: A control write with enable set, start and stop clear, sent while the flag is set and the bus is held, clears the flag and transmits the data register. The status then becomes 0x28 if the byte was ACKed and 0x30 if it was NACKed.
- R6: In read direction, the same kind of write receives one byte into the data register. With control bit 2 (acknowledge) set, the master drives ACK and the status becomes 0x50. With bit 2 clear, it leaves NACK and the status becomes 0x58.
- R7: A control write with enable and bit 4 (stop) set, sent while the bus is held, makes SDA rise while SCL is high. Afterwards the status is 0xF8, the flag is low and both lines are released.
- R8: A start request on a free bus while SDA reads low is dropped. SCL is not pulled, the status stays 0xF8 and the flag stays low.
- R9: A byte request on a free bus, or while the flag is clear, has no effect. SCL stays released, no flag is raised and the status is unchanged.
- R10: During a byte transfer, the master changes SDA only while SCL is low.
- R11: The interrupt output equals the flag, which reads back as bit 3 of the control register (read-select 1). While the flag is set, the status is never 0xF8.
- R12: While another device holds SCL low after the master released it, the transfer stalls and no flag is raised. The transfer completes normally once SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 data, 1 control, 2 soft reset |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read select: 0 data, 1 control, 2 status |
| rd_data_o | output | 8 | Read data (combinational) |
| scl_o | output | 1 | SCL open-drain drive, 1 releases the line |
| sda_o | output | 1 | SDA open-drain drive, 1 releases the line |
| scl_i | input | 1 | SCL line state |
| sda_i | input | 1 | SDA line state |
| irq_o | output | 1 | Interrupt, equal to the event flag |

## Verification
A wrong address or direction latch shows up at the next event as the wrong one of the four address codes. Later, it shows up as data bytes that flow the wrong way, which the bench slave model records. A broken phase sequencer shows at the lines within one quarter-bit, as a false start or stop seen by the slave model, or as an SCL that never toggles. Such a fault surfaces as a missing flag within one byte time. A stale ACK decision appears as the wrong code at the very next flag, or as a mismatch in the master-ACK bit that the slave model captured.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_SRST = 2'd2;

  localparam int CB_CE = 7;
  localparam int CB_EN = 6;
  localparam int CB_STA = 5;
  localparam int CB_STP = 4;
  localparam int CB_FLG = 3;
  localparam int CB_AK = 2;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_DW_NACK = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_BYTE  = 2'd2,
    CMD_STOP  = 2'd3
  } seq_cmd_e;
endpackage

// File: rtl/twm_tick.sv
module twm_tick #(
  parameter int unsigned QTR_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (QTR_CYCLES < 2) ? 1 : $clog2(QTR_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/twm_bit_seq.sv
module twm_bit_seq
  import twm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  seq_cmd_e   cmd_i,
  input  logic [7:0] tx_i,
  input  logic       rx_mode_i,
  input  logic       ack_out_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       busy_o,
  output logic       done_o,
  output seq_cmd_e   done_cmd_o,
  output logic [7:0] rx_o,
  output logic       ack_in_o
);
  seq_cmd_e   cur_q, done_cmd_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       rx_q, ackout_q, ackin_q;
  logic       scl_q, sda_q, done_q;
  logic       adv, last_bit;

  // a phase after an SCL release waits for the wired line to go high
  assign adv      = tick_i && (!scl_q || scl_i);
  assign last_bit = (bit_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= CMD_NONE; done_cmd_q <= CMD_NONE;
      ph_q <= '0; bit_q <= '0; sh_q <= '0;
      rx_q <= 1'b0; ackout_q <= 1'b0; ackin_q <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; done_q <= 1'b0;
    end else if (clr_i) begin
      cur_q <= CMD_NONE; ph_q <= '0; bit_q <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cur_q == CMD_NONE) begin
        if (cmd_i != CMD_NONE) begin
          cur_q <= cmd_i; ph_q <= '0; bit_q <= '0;
          sh_q <= tx_i; rx_q <= rx_mode_i; ackout_q <= ack_out_i; ackin_q <= 1'b0;
        end
      end else if (adv) begin
        ph_q <= ph_q + 2'd1;
        case (cur_q)
          CMD_START: begin
            case (ph_q)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b1;
              2'd2: sda_q <= 1'b0;
              default: begin
                scl_q <= 1'b0; cur_q <= CMD_NONE; done_q <= 1'b1; done_cmd_q <= CMD_START;
              end
            endcase
          end
          CMD_STOP: begin
            case (ph_q)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b1;
              2'd2: sda_q <= 1'b1;
              default: begin
                cur_q <= CMD_NONE; done_q <= 1'b1; done_cmd_q <= CMD_STOP;
              end
            endcase
          end
          CMD_BYTE: begin
            case (ph_q)
              2'd0: begin
                if (last_bit) sda_q <= rx_q ? !ackout_q : 1'b1;
                else          sda_q <= rx_q ? 1'b1 : sh_q[7];
              end
              2'd1: scl_q <= 1'b1;
              2'd2: begin
                if (!last_bit) begin
                  if (rx_q) sh_q <= {sh_q[6:0], sda_i};
                end else begin
                  ackin_q <= !sda_i;
                end
              end
              default: begin
                scl_q <= 1'b0;
                if (last_bit) begin
                  cur_q <= CMD_NONE; done_q <= 1'b1; done_cmd_q <= CMD_BYTE;
                end else begin
                  bit_q <= bit_q + 4'd1;
                  if (!rx_q) sh_q <= {sh_q[6:0], 1'b0};
                end
              end
            endcase
          end
          default: cur_q <= CMD_NONE;
        endcase
      end
    end
  end

  assign scl_o      = scl_q;
  assign sda_o      = sda_q;
  assign busy_o     = (cur_q != CMD_NONE) || done_q;
  assign done_o     = done_q;
  assign done_cmd_o = done_cmd_q;
  assign rx_o       = sh_q;
  assign ack_in_o   = ackin_q;

  AST_START_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == CMD_START && $fell(sda_q)) |-> scl_q); // R2
  AST_STOP_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == CMD_STOP && $rose(sda_q)) |-> scl_q); // R7
  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == CMD_BYTE && $past(cur_q) == CMD_BYTE && $past(scl_q) && scl_q) |-> $stable(sda_q)); // R10
  AST_STALL_LOW_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != CMD_NONE && scl_q && !scl_i && !clr_i) |=> $stable(ph_q)); // R12
endmodule

// File: rtl/twm_byte_engine.sv
module twm_byte_engine
  import twm_pkg::*;
#(
  parameter int unsigned QTR_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_sel_i,
  output logic [7:0] rd_data_o,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       irq_o
);
  logic       ce_q, en_q, aak_q, flag_q;
  logic [7:0] data_q, status_q;
  logic       held_q, addr_q, read_q, rep_q, ack_sent_q;

  logic       busy, done, tick, ack_in;
  seq_cmd_e   done_cmd, cmd;
  logic [7:0] rx_byte;

  logic soft_rst, ctrl_wr, req_en, req_sta, req_stp;
  logic go_start, go_stop, go_byte, start_blocked;

  assign soft_rst = wr_en_i && wr_sel_i == SEL_SRST;
  assign ctrl_wr  = wr_en_i && wr_sel_i == SEL_CTRL && !busy;
  assign req_en   = wr_data_i[CB_EN];
  assign req_sta  = wr_data_i[CB_STA];
  assign req_stp  = wr_data_i[CB_STP];

  assign go_start      = ctrl_wr && req_en && req_sta && (held_q || sda_i);
  assign start_blocked = ctrl_wr && req_en && req_sta && !held_q && !sda_i;
  assign go_stop       = ctrl_wr && req_en && !req_sta && req_stp && held_q;
  assign go_byte       = ctrl_wr && req_en && !req_sta && !req_stp && flag_q && held_q;

  always_comb begin
    cmd = CMD_NONE;
    if (go_start)     cmd = CMD_START;
    else if (go_stop) cmd = CMD_STOP;
    else if (go_byte) cmd = CMD_BYTE;
  end

  twm_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  twm_bit_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst),
    .tick_i     (tick),
    .cmd_i      (cmd),
    .tx_i       (data_q),
    .rx_mode_i  (read_q && !addr_q),
    .ack_out_i  (wr_data_i[CB_AK]),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .busy_o     (busy),
    .done_o     (done),
    .done_cmd_o (done_cmd),
    .rx_o       (rx_byte),
    .ack_in_o   (ack_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b0; en_q <= 1'b0; aak_q <= 1'b0; flag_q <= 1'b0;
      data_q <= '0; status_q <= ST_IDLE;
      held_q <= 1'b0; addr_q <= 1'b0; read_q <= 1'b0; rep_q <= 1'b0; ack_sent_q <= 1'b0;
    end else if (soft_rst) begin
      ce_q <= 1'b0; en_q <= 1'b0; aak_q <= 1'b0; flag_q <= 1'b0;
      status_q <= ST_IDLE;
      held_q <= 1'b0; addr_q <= 1'b0; read_q <= 1'b0; rep_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_DATA && !busy) data_q <= wr_data_i;
      if (ctrl_wr) begin
        ce_q  <= wr_data_i[CB_CE];
        en_q  <= req_en;
        aak_q <= wr_data_i[CB_AK];
        if (go_start || go_stop || go_byte) flag_q <= 1'b0;
        if (go_start) rep_q <= held_q;
        if (go_byte) ack_sent_q <= wr_data_i[CB_AK];
      end
      if (done) begin
        case (done_cmd)
          CMD_START: begin
            status_q <= rep_q ? ST_RESTART : ST_START;
            flag_q <= 1'b1; held_q <= 1'b1; addr_q <= 1'b1;
          end
          CMD_BYTE: begin
            flag_q <= 1'b1;
            if (addr_q) begin
              addr_q <= 1'b0;
              read_q <= data_q[0];
              if (data_q[0]) status_q <= ack_in ? ST_AR_ACK : ST_AR_NACK;
              else           status_q <= ack_in ? ST_AW_ACK : ST_AW_NACK;
            end else if (read_q) begin
              data_q   <= rx_byte;
              status_q <= ack_sent_q ? ST_DR_ACK : ST_DR_NACK;
            end else begin
              status_q <= ack_in ? ST_DW_ACK : ST_DW_NACK;
            end
          end
          CMD_STOP: begin
            status_q <= ST_IDLE;
            held_q <= 1'b0; addr_q <= 1'b0; read_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel_i)
      SEL_DATA: rd_data_o = data_q;
      SEL_CTRL: rd_data_o = {ce_q, en_q, 2'b00, flag_q, aak_q, 2'b00};
      SEL_STAT: rd_data_o = status_q;
      default:  rd_data_o = 8'h00;
    endcase
  end

  assign irq_o = flag_q;

  AST_SOFT_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (status_q == ST_IDLE && !irq_o && scl_o && sda_o)); // R1
  AST_FREE_BUS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_q && !busy) |-> (scl_o && sda_o)); // R7
  AST_BLOCKED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_blocked |=> (!busy && !irq_o && status_q == ST_IDLE)); // R8
  AST_IGNORED_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && req_en && !req_sta && !req_stp && (!flag_q || !held_q)) |=> !busy); // R9
  AST_FLAG_HAS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_q != ST_IDLE); // R11
endmodule

// File: tb/twm_byte_engine_bench.sv
`timescale 1ns/1ps
module twm_byte_engine_bench;
  localparam logic [1:0] S_DATA = 2'd0, S_CTRL = 2'd1, S_STAT = 2'd2, S_RST = 2'd2;
  localparam logic [6:0] SL_ADDR = 7'h50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_sel = S_STAT;
  logic [7:0] rd_data;
  logic scl_o, sda_o, irq_o;

  bit sl_sda = 1'b1, sl_scl = 1'b1, hold_sda = 1'b0;
  wire scl_line = scl_o & sl_scl;
  wire sda_line = sda_o & sl_sda & ~hold_sda;

  int checks = 0, failures = 0;
  logic [7:0] exp_st[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  twm_byte_engine u_twm_byte_engine (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .scl_o(scl_o), .sda_o(sda_o),
    .scl_i(scl_line), .sda_i(sda_line), .irq_o(irq_o)
  );

  // slave model at address 0x50
  int  sl_cnt = -1, tx_idx = 0, start_cnt = 0, stop_cnt = 0, sl_rx_cnt = 0;
  bit  sl_act = 0, sl_first = 0, sl_sel = 0, sl_rd = 0, sl_tx_on = 0, sl_mack = 0, sl_ack_en = 1;
  logic [7:0] sl_sh = 8'h00, sl_txsh = 8'h00, sl_rx_last = 8'h00;
  logic [7:0] tx_data [2] = '{8'h3C, 8'hC3};

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    start_cnt++; sl_act = 1; sl_cnt = -1; sl_first = 1; sl_sel = 0; sl_rd = 0; sl_tx_on = 0; sl_sda = 1;
  end
  always @(posedge sda_line) if (scl_line === 1'b1 && sl_act) begin
    stop_cnt++; sl_act = 0; sl_sda = 1;
  end
  always @(posedge scl_line) if (sl_act) begin
    if (sl_cnt >= 0 && sl_cnt < 8) sl_sh = {sl_sh[6:0], sda_line};
    else if (sl_cnt == 8 && sl_tx_on) begin
      sl_mack = !sda_line;
      if (sda_line) sl_sel = 0;
    end
  end
  always @(negedge scl_line) if (sl_act) begin
    sl_cnt++;
    if (sl_cnt == 8) begin
      sl_sda = 1;
      if (sl_first) begin
        sl_sel = (sl_sh[7:1] == SL_ADDR); sl_rd = sl_sh[0];
        if (sl_sel) sl_sda = 0;
      end else if (sl_sel && !sl_rd) begin
        sl_rx_last = sl_sh; sl_rx_cnt++;
        if (sl_ack_en) sl_sda = 0;
      end
    end else if (sl_cnt == 9) begin
      sl_cnt = 0; sl_first = 0; sl_sda = 1; sl_tx_on = sl_sel && sl_rd;
      if (sl_tx_on) begin
        sl_txsh = tx_data[tx_idx % 2]; tx_idx++; sl_sda = sl_txsh[7];
      end
    end else if (sl_tx_on && sl_cnt >= 1 && sl_cnt <= 7) begin
      sl_sda = sl_txsh[7 - sl_cnt];
    end
  end

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); rd_sel = sel; #1; d = rd_data;
    @(negedge clk); rd_sel = S_STAT;
  endtask

  task automatic expect_evt(input logic [7:0] st, input string tag);
    exp_st.push_back(st); exp_tag.push_back(tag);
  endtask

  task automatic wait_evt(input string tag);
    for (int i = 0; i < 4000 && !irq_o; i++) @(negedge clk);
    check8({7'd0, irq_o}, 8'd1, {tag, " flag raised"});
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic [7:0] ctl, input logic [7:0] st, input string tag);
    expect_evt(st, tag);
    reg_wr(S_CTRL, ctl);
    wait_evt(tag);
  endtask

  // monitor: pop expected status on every new flag
  always @(posedge irq_o) begin
    @(negedge clk);
    if (exp_st.size() == 0) begin
      checks++; failures++;
      $display("FAIL R11 unexpected event actual=%h expected=none", rd_data);
    end else begin
      logic [7:0] st;
      string tg;
      st = exp_st.pop_front(); tg = exp_tag.pop_front();
      check8(rd_data, st, tg);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int lows;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    start_cnt = 0; stop_cnt = 0;
    @(negedge clk);

    // R1 reset state
    check8(rd_data, 8'hF8, "R1 reset status");
    check8({6'd0, scl_o, sda_o}, 8'h03, "R1 reset lines");
    check8({7'd0, irq_o}, 8'h00, "R1 reset irq");

    // R2 start, R4 write address, R5 data
    reg_wr(S_DATA, {SL_ADDR, 1'b0});
    step(8'h60, 8'h08, "R2 start");
    check8(8'(start_cnt), 8'd1, "R2 start condition on bus");
    reg_rd(S_CTRL, r);
    check8(r & 8'h08, 8'h08, "R11 flag in ctrl");
    step(8'h40, 8'h18, "R4 write address ack");
    reg_wr(S_DATA, 8'hA5);
    step(8'h40, 8'h28, "R5 data ack");
    check8(sl_rx_last, 8'hA5, "R5 byte on bus");
    sl_ack_en = 0;
    reg_wr(S_DATA, 8'h5A);
    step(8'h40, 8'h30, "R5 data nack");
    check8(sl_rx_last, 8'h5A, "R5 second byte");
    sl_ack_en = 1;

    // R3 repeated start, read flow R4 R6
    reg_wr(S_DATA, {SL_ADDR, 1'b1});
    step(8'h60, 8'h10, "R3 repeated start");
    check8(8'(start_cnt), 8'd2, "R3 start count");
    step(8'h40, 8'h40, "R4 read address ack");
    step(8'h44, 8'h50, "R6 read with ack");
    reg_rd(S_DATA, r);
    check8(r, 8'h3C, "R6 first rx byte");
    check8({7'd0, sl_mack}, 8'd1, "R6 master ack");
    step(8'h40, 8'h58, "R6 read with nack");
    reg_rd(S_DATA, r);
    check8(r, 8'hC3, "R6 last rx byte");
    check8({7'd0, sl_mack}, 8'd0, "R6 master nack");

    // R7 stop
    reg_wr(S_CTRL, 8'h50);
    repeat (100) @(negedge clk);
    check8(rd_data, 8'hF8, "R7 status after stop");
    check8({6'd0, irq_o, scl_o, sda_o}, 8'h03, "R7 irq and lines");
    check8(8'(stop_cnt), 8'd1, "R7 stop condition");

    // R9 byte request on free bus
    reg_wr(S_CTRL, 8'h40);
    lows = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!scl_o) lows++; end
    check8(8'(lows), 8'd0, "R9 no scl activity");
    check8(rd_data, 8'hF8, "R9 status unchanged");
    check8({7'd0, irq_o}, 8'd0, "R9 no flag");

    // R4 nack codes on an absent target
    reg_wr(S_DATA, 8'h46);
    step(8'h60, 8'h08, "R2 start again");
    step(8'h40, 8'h20, "R4 write address nack");
    reg_wr(S_DATA, 8'h47);
    step(8'h60, 8'h10, "R3 restart again");
    step(8'h40, 8'h48, "R4 read address nack");
    reg_wr(S_CTRL, 8'h50);
    repeat (100) @(negedge clk);
    check8(rd_data, 8'hF8, "R7 second stop");

    // R8 start refused while SDA low
    hold_sda = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr(S_CTRL, 8'h60);
    lows = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!scl_o) lows++; end
    check8(8'(lows), 8'd0, "R8 scl untouched");
    check8(rd_data, 8'hF8, "R8 status idle");
    check8({7'd0, irq_o}, 8'd0, "R8 no flag");
    hold_sda = 1'b0;
    repeat (4) @(negedge clk);

    // R12 clock stretch
    reg_wr(S_DATA, {SL_ADDR, 1'b0});
    step(8'h60, 8'h08, "R2 start before stretch");
    sl_scl = 1'b0;
    expect_evt(8'h18, "R12 address after stretch");
    reg_wr(S_CTRL, 8'h40);
    repeat (500) @(negedge clk);
    check8({7'd0, irq_o}, 8'd0, "R12 stalled while scl low");
    sl_scl = 1'b1;
    wait_evt("R12 completes");

    // R1 soft reset mid byte
    reg_wr(S_DATA, 8'h77);
    reg_wr(S_CTRL, 8'h40);
    repeat (60) @(negedge clk);
    reg_wr(S_RST, 8'h00);
    check8(rd_data, 8'hF8, "R1 soft reset status");
    check8({6'd0, irq_o, scl_o, sda_o}, 8'h03, "R1 soft reset irq and lines");
    repeat (400) @(negedge clk);
    check8({7'd0, irq_o}, 8'd0, "R1 no late event");
    check8(8'(exp_st.size()), 8'd0, "R11 all events seen");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule